// File: doc/BRIEF.md
# Register Window Spill/Fill Engine

This block moves one register window between the register file and the stack in hardware, so that a window overflow or underflow needs no software trap handler. On an overflow (spill) it reads the stack pointer of the window next to the current one in the call direction. It then writes that window's eight local and eight input registers to memory as eight doublewords, placed at the stack pointer and the seven doubleword offsets above it. On an underflow (fill) it does the same for the window next to the current one in the return direction, but reads the doublewords from memory and writes them into the register file. At the end it presents a new invalid-window mask, rotated one position in the direction that matches the event.

A requester starts a job with a one-cycle request that carries the direction, the current window pointer and the current invalid-window mask. The engine holds `busy` high until the job is finished. While `busy` is high the requester stalls and treats window-invalid checking as suspended. The memory side is a valid/ready stream of doubleword transfers. The engine raises `mem_valid` and keeps the address, the direction and the write data steady until the memory raises `mem_ready`. A beat completes on the clock edge where both are high, and only then does the next beat start. The memory may hold `mem_ready` low for any number of cycles. During a fill, read data must be valid in the cycle where `mem_ready` is high. The register file gives read data combinationally for the window and even register number that the engine drives, and returns the pair `rf_reg`/`rf_reg+1`.

Top module: `regwin_spill_fill`

## Requirements
- R1: After reset, `busy`, `mem_valid`, `rf_we` and `done` are all 0.
- R2: A request is taken when `req_valid` is 1 and `busy` is 0. The target window is `req_cwp-1` (mod NWIN) for a spill (`req_fill`=0) and `req_cwp+1` (mod NWIN) for a fill (`req_fill`=1). The first thing the engine does is read register 14 (the stack pointer) of the target window.
- R3: The job makes exactly eight memory beats, k=0..7 in ascending order. Beat k uses address SP+8k and register pair 16+2k / 17+2k of the target window, so locals are handled before inputs.
- R4: On a spill, `mem_write` is 1 and `mem_wdata[63:32]` is the even register of the pair, with the odd register in `mem_wdata[31:0]`.
- R5: On a fill, `mem_write` is 0, and `rf_we` is 1 only in handshake cycles. In those cycles `rf_wr_even` equals `mem_rdata[63:32]` and `rf_wr_odd` equals `mem_rdata[31:0]`.
- R6: While `mem_valid` is 1 and `mem_ready` is 0, the next cycle still has `mem_valid` 1 with the same address and direction.
- R7: One cycle after the eighth handshake, `done` is 1 for exactly one cycle. For a spill, `wim_new` then equals the request mask rotated right by one with wrap-around ({wim[0], wim[NWIN-1:1]}).
- R8: For a fill, `wim_new` at `done` equals the request mask rotated left by one with wrap-around ({wim[NWIN-2:0], wim[NWIN-1]}).
- R9: `busy` is 1 from the cycle after acceptance through the `done` cycle and 0 afterwards. A request made while `busy` is 1 is ignored: it does not change the target, the beats or the mask, and it does not start a second job.
- R10: Window wrap works at both ends: a spill from window 0 targets window NWIN-1, and a fill from window NWIN-1 targets window 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request (taken when not busy) |
| req_fill | input | 1 | 0 = spill (overflow), 1 = fill (underflow) |
| req_cwp | input | WPW | Current window pointer |
| req_wim | input | NWIN | Current invalid-window mask |
| busy | output | 1 | Job in progress; requester stalls |
| rf_win | output | WPW | Register-file window selected |
| rf_reg | output | 5 | Even register number of the pair read or written |
| rf_rd_even | input | XLEN | Read data of register `rf_reg` |
| rf_rd_odd | input | XLEN | Read data of register `rf_reg+1` |
| rf_we | output | 1 | Register pair write enable (fill) |
| rf_wr_even | output | XLEN | Write data for register `rf_reg` |
| rf_wr_odd | output | XLEN | Write data for register `rf_reg+1` |
| mem_valid | output | 1 | Doubleword beat valid |
| mem_write | output | 1 | 1 = store, 0 = load |
| mem_addr | output | AW | Byte address of the beat |
| mem_wdata | output | 2*XLEN | Store data, even register high |
| mem_ready | input | 1 | Memory accepts / completes the beat |
| mem_rdata | input | 2*XLEN | Load data, valid with `mem_ready` |
| done | output | 1 | One-cycle end-of-job pulse |
| wim_new | output | NWIN | Rotated mask, valid with `done` |

## Verification
If the engine computes the wrong target window or latches the stack pointer at the wrong time, the first beat shows it at once through a wrong address or wrong store data. If the beat counter is off, a register pair is skipped or repeated, which shows up as a wrong address on the next beat, or as a `done` that comes too early or too late compared with the eighth handshake. If the mask is rotated the wrong way, or the wrap bit is lost, this is visible only in the single `done` cycle, so the checks on the wrap-around cases look at that cycle. If a request taken while busy were able to restart the sequencer, the following beat would show a different direction or base address, or a second run of beats would follow `done`.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  // Architectural register numbering inside one window
  localparam int unsigned RIDX_W    = 5;
  localparam logic [RIDX_W-1:0] SP_REG    = 5'd14;  // out register 6
  localparam logic [RIDX_W-1:0] FIRST_REG = 5'd16;  // local register 0
  localparam int unsigned BEATS     = 8;            // 16 registers as pairs

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SP,
    ST_XFER,
    ST_DONE
  } rw_state_e;
endpackage

// File: rtl/rw_target.sv
module rw_target #(
  parameter int unsigned NWIN = 8,
  localparam int unsigned WPW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            fill,
  input  logic [WPW-1:0]  cwp,
  input  logic [NWIN-1:0] wim,
  output logic [WPW-1:0]  tgt,
  output logic [NWIN-1:0] wim_rot
);
  logic [WPW-1:0] nxt, prv;

  generate
    if ((1 << WPW) == NWIN) begin : g_pow2
      assign nxt = cwp + WPW'(1);
      assign prv = cwp - WPW'(1);
    end else begin : g_npow2
      assign nxt = (cwp == WPW'(NWIN-1)) ? '0 : cwp + WPW'(1);
      assign prv = (cwp == '0) ? WPW'(NWIN-1) : cwp - WPW'(1);
    end
  endgenerate

  assign tgt     = fill ? nxt : prv;
  assign wim_rot = fill ? {wim[NWIN-2:0], wim[NWIN-1]}
                        : {wim[0], wim[NWIN-1:1]};
endmodule

// File: rtl/rw_seq.sv
module rw_seq
  import regwin_pkg::*;
#(
  parameter int unsigned NBEAT = BEATS,
  localparam int unsigned BW = $clog2(NBEAT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          beat_hs,
  output rw_state_e     state,
  output logic [BW-1:0] beat
);
  localparam logic [BW-1:0] LAST = BW'(NBEAT-1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      beat  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_SP;
          beat  <= '0;
        end
        ST_SP:   state <= ST_XFER;
        ST_XFER: if (beat_hs) begin
          if (beat == LAST) state <= ST_DONE;
          else              beat  <= beat + BW'(1);
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rw_beat_map.sv
module rw_beat_map
  import regwin_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned XLEN = 32,
  parameter int unsigned BW   = 3,
  localparam int unsigned DBYTES = (2*XLEN)/8
) (
  input  logic              sp_phase,
  input  logic [BW-1:0]     beat,
  input  logic [AW-1:0]     sp,
  output logic [RIDX_W-1:0] reg_idx,
  output logic [AW-1:0]     addr
);
  assign reg_idx = sp_phase ? SP_REG
                            : FIRST_REG + RIDX_W'({beat, 1'b0});
  assign addr    = sp + AW'(beat) * AW'(DBYTES);
endmodule

// File: rtl/regwin_spill_fill.sv
module regwin_spill_fill
  import regwin_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 32,
  localparam int unsigned WPW = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int unsigned BW  = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_fill,
  input  logic [WPW-1:0]    req_cwp,
  input  logic [NWIN-1:0]   req_wim,
  output logic              busy,
  output logic [WPW-1:0]    rf_win,
  output logic [RIDX_W-1:0] rf_reg,
  input  logic [XLEN-1:0]   rf_rd_even,
  input  logic [XLEN-1:0]   rf_rd_odd,
  output logic              rf_we,
  output logic [XLEN-1:0]   rf_wr_even,
  output logic [XLEN-1:0]   rf_wr_odd,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [AW-1:0]     mem_addr,
  output logic [2*XLEN-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [2*XLEN-1:0] mem_rdata,
  output logic              done,
  output logic [NWIN-1:0]   wim_new
);
  rw_state_e      state;
  logic [BW-1:0]  beat;
  logic           accept, beat_hs;
  logic           fill_q;
  logic [WPW-1:0] tgt_d, tgt_q;
  logic [NWIN-1:0] rot_d, rot_q;
  logic [AW-1:0]  sp_q;

  assign accept  = req_valid && (state == ST_IDLE);
  assign beat_hs = mem_valid && mem_ready;

  rw_target #(.NWIN(NWIN)) u_target (
    .fill    (req_fill),
    .cwp     (req_cwp),
    .wim     (req_wim),
    .tgt     (tgt_d),
    .wim_rot (rot_d)
  );

  rw_seq #(.NBEAT(BEATS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .beat_hs (beat_hs),
    .state   (state),
    .beat    (beat)
  );

  rw_beat_map #(.AW(AW), .XLEN(XLEN), .BW(BW)) u_map (
    .sp_phase (state == ST_SP),
    .beat     (beat),
    .sp       (sp_q),
    .reg_idx  (rf_reg),
    .addr     (mem_addr)
  );

  // Job context is latched at acceptance, stack pointer one cycle later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= 1'b0;
      tgt_q  <= '0;
      rot_q  <= '0;
      sp_q   <= '0;
    end else begin
      if (accept) begin
        fill_q <= req_fill;
        tgt_q  <= tgt_d;
        rot_q  <= rot_d;
      end
      if (state == ST_SP) sp_q <= AW'(rf_rd_even);
    end
  end

  assign busy       = (state != ST_IDLE);
  assign rf_win     = tgt_q;
  assign mem_valid  = (state == ST_XFER);
  assign mem_write  = !fill_q;
  assign mem_wdata  = {rf_rd_even, rf_rd_odd};
  assign rf_we      = beat_hs && fill_q;
  assign rf_wr_even = mem_rdata[2*XLEN-1:XLEN];
  assign rf_wr_odd  = mem_rdata[XLEN-1:0];
  assign done       = (state == ST_DONE);
  assign wim_new    = rot_q;
endmodule

// File: rtl/regwin_spill_fill_checker.sv
module regwin_spill_fill_checker #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned AW   = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          rf_we,
  input logic          mem_valid,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready,
  input logic          done
);
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write)); // R6

  AST_ACK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=> !mem_valid || (mem_addr != $past(mem_addr))); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_AFTER_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy && !mem_valid && $past(mem_valid && mem_ready)); // R7

  AST_IDLE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid && !rf_we); // R9

  AST_WE_ON_LOAD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> mem_valid && mem_ready && !mem_write); // R5
endmodule

bind regwin_spill_fill regwin_spill_fill_checker #(.NWIN(NWIN), .AW(AW)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .rf_we     (rf_we),
  .mem_valid (mem_valid),
  .mem_write (mem_write),
  .mem_addr  (mem_addr),
  .mem_ready (mem_ready),
  .done      (done)
);

// File: tb/regwin_spill_fill_bench.sv
module regwin_spill_fill_bench;
  localparam int NWIN = 8;
  localparam int XLEN = 32;
  localparam int AW   = 32;
  localparam int WPW  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_fill = 1'b0;
  logic [WPW-1:0]    req_cwp = '0;
  logic [NWIN-1:0]   req_wim = '0;
  logic              busy;
  logic [WPW-1:0]    rf_win;
  logic [4:0]        rf_reg;
  logic [XLEN-1:0]   rf_rd_even, rf_rd_odd;
  logic              rf_we;
  logic [XLEN-1:0]   rf_wr_even, rf_wr_odd;
  logic              mem_valid, mem_write;
  logic [AW-1:0]     mem_addr;
  logic [2*XLEN-1:0] mem_wdata;
  logic              mem_ready = 1'b0;
  logic [2*XLEN-1:0] mem_rdata = '0;
  logic              done;
  logic [NWIN-1:0]   wim_new;

  logic [XLEN-1:0] rfm [NWIN][32];
  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  assign rf_rd_even = rfm[rf_win][rf_reg];
  assign rf_rd_odd  = rfm[rf_win][rf_reg + 5'd1];

  regwin_spill_fill #(.NWIN(NWIN), .XLEN(XLEN), .AW(AW)) u_regwin_spill_fill (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fill(req_fill),
    .req_cwp(req_cwp), .req_wim(req_wim), .busy(busy), .rf_win(rf_win),
    .rf_reg(rf_reg), .rf_rd_even(rf_rd_even), .rf_rd_odd(rf_rd_odd),
    .rf_we(rf_we), .rf_wr_even(rf_wr_even), .rf_wr_odd(rf_wr_odd),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .done(done), .wim_new(wim_new)
  );

  // {fill, cwp, wim, sp, expected wim, ack latency}
  localparam logic [53:0] VEC [6] = '{
    {1'b0, 3'd3, 8'h04, 32'h0000_1000, 8'h02, 2'd0},
    {1'b1, 3'd3, 8'h10, 32'h0000_2040, 8'h20, 2'd1},
    {1'b0, 3'd0, 8'h80, 32'h0000_3000, 8'h40, 2'd2},
    {1'b1, 3'd7, 8'h01, 32'h0000_4F80, 8'h02, 2'd3},
    {1'b0, 3'd1, 8'h01, 32'h0000_5000, 8'h80, 2'd1},
    {1'b1, 3'd5, 8'h80, 32'h0000_6008, 8'h01, 2'd0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rval(int w, int r);
    return 32'hC0DE_0000 | 32'(w << 8) | 32'(r);
  endfunction

  task automatic run_case(input bit fill, input int cwp, input logic [7:0] wim,
                          input logic [31:0] sp, input logic [7:0] exp_wim,
                          input int lat, input bit poke, input int id);
    int t;
    t = fill ? (cwp + 1) % NWIN : (cwp + NWIN - 1) % NWIN;
    rfm[t][14] = sp;
    @(negedge clk);
    req_valid = 1'b1; req_fill = fill; req_cwp = WPW'(cwp); req_wim = wim;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9", "busy after accept", 64'(busy), 64'd1);
    chk(rf_win == WPW'(t), fill ? "R10" : "R2", "target window", 64'(rf_win), 64'(t));
    chk(rf_reg == 5'd14, "R2", "stack pointer read", 64'(rf_reg), 64'd14);
    for (int k = 0; k < 8; k++) begin
      logic [63:0] rd;
      while (!mem_valid) @(negedge clk);
      if (poke && k == 3) begin
        req_valid = 1'b1; req_fill = ~fill; req_cwp = 3'd2; req_wim = 8'hFF;
        @(negedge clk);
        req_valid = 1'b0;
      end
      chk(mem_addr == sp + 32'(8*k), "R3", "beat address", 64'(mem_addr), 64'(sp + 32'(8*k)));
      chk(rf_reg == 5'(16 + 2*k), "R3", "register pair", 64'(rf_reg), 64'(16 + 2*k));
      chk(mem_write == !fill, fill ? "R5" : "R4", "direction", 64'(mem_write), 64'(!fill));
      if (!fill)
        chk(mem_wdata == {rval(t, 16+2*k), rval(t, 17+2*k)}, "R4", "store data",
            mem_wdata, {rval(t, 16+2*k), rval(t, 17+2*k)});
      for (int s = 0; s < lat; s++) begin
        @(negedge clk);
        chk(mem_valid && mem_addr == sp + 32'(8*k), "R6", "held during stall",
            64'(mem_addr), 64'(sp + 32'(8*k)));
        chk(rf_we == 1'b0, "R5", "no write while stalled", 64'(rf_we), 64'd0);
      end
      rd = {32'hE000_0000 | 32'(id*16 + 2*k), 32'hE100_0000 | 32'(id*16 + 2*k + 1)};
      mem_ready = 1'b1; mem_rdata = rd;
      #1;
      chk(rf_we == fill, "R5", "write enable on ack", 64'(rf_we), 64'(fill));
      if (fill) begin
        chk(rf_wr_even == rd[63:32] && rf_wr_odd == rd[31:0] && rf_reg == 5'(16+2*k),
            "R5", "fill pair", {rf_wr_even, rf_wr_odd}, rd);
      end
      chk(done == 1'b0, "R7", "no early done", 64'(done), 64'd0);
      @(negedge clk);
      mem_ready = 1'b0;
    end
    chk(done == 1'b1, "R7", "done after eighth beat", 64'(done), 64'd1);
    chk(mem_valid == 1'b0, "R3", "no ninth beat", 64'(mem_valid), 64'd0);
    chk(wim_new == exp_wim, fill ? "R8" : "R7", "rotated mask", 64'(wim_new), 64'(exp_wim));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9", "idle after done", {done, busy}, 64'd0);
  endtask

  initial begin
    for (int w = 0; w < NWIN; w++)
      for (int r = 0; r < 32; r++) rfm[w][r] = rval(w, r);
    repeat (2) @(negedge clk);
    chk(busy == 0 && mem_valid == 0 && rf_we == 0 && done == 0, "R1", "reset outputs",
        {busy, mem_valid, rf_we, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && mem_valid == 0, "R1", "idle after reset", {busy, mem_valid}, 64'd0);

    for (int i = 0; i < 6; i++)
      run_case(VEC[i][53], int'(VEC[i][52:50]), VEC[i][49:42], VEC[i][41:10],
               VEC[i][9:2], int'(VEC[i][1:0]), 1'b0, i);

    // R9: request during a spill is ignored, no second job afterwards
    run_case(1'b0, 6, 8'h20, 32'h0000_7000, 8'h10, 2, 1'b1, 7);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(busy == 0 && mem_valid == 0, "R9", "no job from ignored request",
          {busy, mem_valid}, 64'd0);
    end

    // R10: spill from window 0 once more, with slow memory
    run_case(1'b0, 0, 8'h80, 32'h0000_8100, 8'h40, 3, 1'b0, 8);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R9 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule